// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block routes external interrupt lines to processors in a small multiprocessor system. It has 24 input lines, and each line has its own redirection entry. The entry holds the vector to deliver, an edge or level trigger choice, an input polarity, a mask, a destination addressing mode and a destination processor number. Each input passes through a two-flop synchronizer and is then adjusted for its polarity. It is then either captured as an edge event or followed as a level. When an unmasked line becomes pending, the block emits a delivery message carrying that line's vector, destination and destination mode. The message leaves over a valid/ready handshake.

Software sees only two 32-bit bus locations. The selector at byte offset 0x00 picks an internal register. The window at byte offset 0x10 reads or writes the register that the selector points to. The internal space holds three things:
- an identification register;
- a read-only capability register;
- two words per line for the redirection entries.

When several lines are pending at once, the lowest-numbered line is delivered first.

Top module: `irq_redirect`

## Requirements
- R1: After reset the selector reads 0. Every entry's low word reads 0x00010000, which means masked, with all other fields zero. Every high word reads 0.
- R2: Internal index 0x00 is the identification register. Its controller number sits in bits 31:24 and resets to the CTRL_ID parameter, 0x02 by default. Only bits 31:24 are writable, and all other bits read 0.
- R3: Internal index 0x01 is read-only. It reads the number of lines minus one in bits 23:16 (23 = 0x17) and the implementation version 0x11 in bits 7:0. All other bits are 0.
- R4: Line n has its low word at index 0x10+2n and its high word at 0x11+2n. The low word fields are:
  - vector in bits 7:0;
  - logical destination mode in bit 11;
  - active-low polarity in bit 13;
  - level trigger in bit 15;
  - mask in bit 16.
  The high word holds the destination number in bits 31:24. All other bits read 0.
- R5: Indices that hold no register read 0, and writes to them change nothing. This covers 0x02 to 0x0F and anything above 0x3F. The selector itself reads back on bus offset 0x00 and changes only when software writes to it.
- R6: An unmasked edge-mode line produces exactly one message for each rising edge of its conditioned request. A request that stays asserted produces no further messages.
- R7: A masked line produces no message.
- R8: With the polarity bit set, a falling input counts as the request's rising edge.
- R9: An unmasked level-mode line keeps producing messages for as long as its request stays asserted. A message already offered is still delivered after the request drops. No further messages follow.
- R10: When several lines are pending together, messages leave in ascending line order.
- R11: While msg_valid is high and msg_ready is low, the message payload and msg_valid hold steady.
- R12: A message carries the line's vector, its destination number and its destination-mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset (0x00 selector, 0x10 data window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_sel |
| irq_in | input | 24 | Asynchronous interrupt inputs |
| msg_valid | output | 1 | Delivery message offered |
| msg_ready | input | 1 | Delivery message accepted |
| msg_vector | output | 8 | Vector of the delivered line |
| msg_dest | output | 8 | Destination processor number |
| msg_logical | output | 1 | Destination mode: 1 = logical |

## Verification
The bench targets four corner cases:
- **Edge line held high.** A line in edge mode is held high long after its first message. A design that confuses edge with level would keep sending repeats.
- **Three lines in one cycle, receiver stalled.** Three lines fire in the same cycle while the receiver is stalled. Wrong arbitration shows up as messages out of ascending order. A payload that moves during the stall shows up as a vector other than the lowest line's.
- **Active-low line.** An active-low line is armed while its input idles high. Mishandled polarity either fires when the line is configured or misses the falling input.
- **Edge of the index space.** The top entry, the gap below the entries, and the first index past the table are all accessed. Decode errors there would corrupt neighbouring entries or read back junk.

// File: rtl/irq_redirect.sv
module irq_redirect #(
  parameter int NUM_LINES = 24,
  parameter logic [7:0] CTRL_ID = 8'h02,
  parameter logic [7:0] IMPL_VER = 8'h11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [4:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [7:0]           msg_vector,
  output logic [7:0]           msg_dest,
  output logic                 msg_logical
);
  localparam int LW = $clog2(NUM_LINES);
  localparam int TOP_IDX = 16 + 2*NUM_LINES - 1;
  localparam logic [7:0] LAST_LINE = 8'(NUM_LINES - 1);

  logic [7:0] idx, id_q;
  logic [7:0] vec_q [NUM_LINES];
  logic [7:0] dest_q [NUM_LINES];
  logic [NUM_LINES-1:0] mask_q, lvl_q, pol_q, log_q;
  logic [NUM_LINES-1:0] s1, s2, req_d, epend;
  logic [LW-1:0] pick, msg_line;

  wire [NUM_LINES-1:0] req  = s2 ^ pol_q;
  wire [NUM_LINES-1:0] rise = req & ~req_d;
  wire [NUM_LINES-1:0] pend = ~mask_q & ((lvl_q & req) | (~lvl_q & epend));
  wire any_pend = |pend;
  wire hs = msg_valid && msg_ready;

  wire wr_idx = bus_sel && bus_we && bus_addr == 5'h00;
  wire wr_dat = bus_sel && bus_we && bus_addr == 5'h10;
  wire in_tab = idx >= 8'h10 && idx <= 8'(TOP_IDX);
  wire [7:0] rel = idx - 8'h10;
  wire [LW-1:0] ent = rel[LW:1];
  wire hi = idx[0];

  wire unused_bits = ^{bus_wdata[23:17], bus_wdata[14], bus_wdata[12], bus_wdata[10:8],
                       rel[7:LW+1], rel[0]};

  always_comb begin
    pick = '0;
    for (int i = NUM_LINES-1; i >= 0; i--)
      if (pend[i]) pick = LW'(i);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (bus_addr == 5'h00) bus_rdata = {24'b0, idx};
      else if (bus_addr == 5'h10) begin
        if (idx == 8'h00) bus_rdata = {id_q, 24'b0};
        else if (idx == 8'h01) bus_rdata = {8'b0, LAST_LINE, 8'b0, IMPL_VER};
        else if (in_tab && hi) bus_rdata = {dest_q[ent], 24'b0};
        else if (in_tab) bus_rdata = {15'b0, mask_q[ent], lvl_q[ent], 1'b0, pol_q[ent],
                                      1'b0, log_q[ent], 3'b0, vec_q[ent]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      id_q <= CTRL_ID;
      mask_q <= '1;
      lvl_q <= '0;
      pol_q <= '0;
      log_q <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        vec_q[i] <= '0;
        dest_q[i] <= '0;
      end
    end else begin
      if (wr_idx) idx <= bus_wdata[7:0];
      if (wr_dat) begin
        if (idx == 8'h00) id_q <= bus_wdata[31:24];
        else if (in_tab && hi) dest_q[ent] <= bus_wdata[31:24];
        else if (in_tab) begin
          mask_q[ent] <= bus_wdata[16];
          lvl_q[ent]  <= bus_wdata[15];
          pol_q[ent]  <= bus_wdata[13];
          log_q[ent]  <= bus_wdata[11];
          vec_q[ent]  <= bus_wdata[7:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      req_d <= '0;
      epend <= '0;
    end else begin
      s1 <= irq_in;
      s2 <= s1;
      req_d <= req;
      for (int i = 0; i < NUM_LINES; i++) begin
        if (rise[i] && !mask_q[i] && !lvl_q[i]) epend[i] <= 1'b1;
        else if (hs && msg_line == LW'(i)) epend[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_vector <= '0;
      msg_dest <= '0;
      msg_logical <= 1'b0;
      msg_line <= '0;
    end else if (hs) begin
      msg_valid <= 1'b0;
    end else if (!msg_valid && any_pend) begin
      msg_valid <= 1'b1;
      msg_vector <= vec_q[pick];
      msg_dest <= dest_q[pick];
      msg_logical <= log_q[pick];
      msg_line <= pick;
    end
  end

  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest)
                                && $stable(msg_logical));
  a_r6_one_per_accept: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> !msg_valid);
  a_r7_unmasked_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(!mask_q[pick] && any_pend));
  a_r5_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we && bus_addr == 5'h00) |=> $stable(idx));
endmodule

// File: tb/tb_irq_redirect.sv
module tb_irq_redirect;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [23:0] irq_in = '0;
  logic msg_valid, msg_ready = 1, msg_logical;
  logic [7:0] msg_vector, msg_dest;

  int checks = 0, fails = 0, seen = 0;
  logic [16:0] expq[$];

  always #4 clk = ~clk;

  irq_redirect dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dest(msg_dest), .msg_logical(msg_logical));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [31:0] d);
    bus_write(5'h00, {24'b0, i});
    bus_write(5'h10, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [31:0] d);
    bus_write(5'h00, {24'b0, i});
    bus_read(5'h10, d);
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk); #2 msg_ready = v;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      seen++;
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6/R7 unexpected message actual=0x%05h expected=none",
                 {msg_vector, msg_dest, msg_logical});
      end else
        check("R12 message payload", {15'b0, msg_vector, msg_dest, msg_logical},
              {15'b0, expq.pop_front()});
    end
  end

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    cycles(5);
    @(negedge clk) rst_n = 1;

    bus_read(5'h00, d);        check("R1 selector reset", d, 32'h0);
    reg_rd(8'h10, d);          check("R1 line0 low reset", d, 32'h00010000);
    reg_rd(8'h11, d);          check("R1 line0 high reset", d, 32'h0);
    reg_rd(8'h3E, d);          check("R1 line23 low reset", d, 32'h00010000);

    reg_rd(8'h00, d);          check("R2 id reset", d, 32'h02000000);
    reg_wr(8'h00, 32'hAB123456);
    reg_rd(8'h00, d);          check("R2 id write", d, 32'hAB000000);
    reg_rd(8'h01, d);          check("R3 version", d, 32'h00170011);
    reg_wr(8'h01, 32'hFFFFFFFF);
    reg_rd(8'h01, d);          check("R3 version read-only", d, 32'h00170011);

    reg_wr(8'h3E, 32'hFFFFFFFF);
    reg_rd(8'h3E, d);          check("R4 low word fields", d, 32'h0001A8FF);
    reg_wr(8'h3F, 32'hFFFFFFFF);
    reg_rd(8'h3F, d);          check("R4 high word fields", d, 32'hFF000000);
    reg_wr(8'h3E, 32'h00010000);

    reg_wr(8'h05, 32'hFFFFFFFF);
    reg_rd(8'h05, d);          check("R5 gap index", d, 32'h0);
    reg_wr(8'h40, 32'hFFFFFFFF);
    bus_read(5'h00, d);        check("R5 selector readback", d, 32'h40);
    bus_read(5'h10, d);        check("R5 past table", d, 32'h0);
    reg_rd(8'h3F, d);          check("R5 neighbour high intact", d, 32'hFF000000);
    reg_rd(8'h3E, d);          check("R5 neighbour low intact", d, 32'h00010000);

    // R7: line 5 stays masked
    irq_in[5] = 1; cycles(6); irq_in[5] = 0; cycles(20);
    check("R7 masked line silent", seen, 0);

    // R6/R12: edge line 3, logical mode
    reg_wr(8'h16, 32'h00000833);
    reg_wr(8'h17, 32'h05000000);
    expq.push_back({8'h33, 8'h05, 1'b1});
    @(negedge clk) irq_in[3] = 1;
    cycles(30);
    check("R6 single message on held edge", seen, 1);
    irq_in[3] = 0; cycles(5);

    // R8: active-low line 4
    irq_in[4] = 1; cycles(5);
    reg_wr(8'h18, 32'h00002044);
    reg_wr(8'h19, 32'h07000000);
    cycles(10);
    check("R8 no fire on arming", seen, 1);
    expq.push_back({8'h44, 8'h07, 1'b0});
    @(negedge clk) irq_in[4] = 0;
    cycles(20);
    check("R8 falling input delivers", seen, 2);

    // R10/R11: three simultaneous lines, receiver stalled
    set_ready(0);
    reg_wr(8'h38, 32'h00000060); reg_wr(8'h39, 32'h01000000);
    reg_wr(8'h22, 32'h00000059); reg_wr(8'h23, 32'h02000000);
    reg_wr(8'h14, 32'h00000052); reg_wr(8'h15, 32'h03000000);
    base = seen;
    @(negedge clk) irq_in = irq_in | 24'h100204;
    cycles(5);
    @(negedge clk) irq_in = irq_in & ~24'h100204;
    cycles(10);
    @(negedge clk);
    check("R11 valid held in stall", {31'b0, msg_valid}, 1);
    check("R10 lowest line offered first", {24'b0, msg_vector}, 32'h52);
    check("R11 no accept during stall", seen, base);
    expq.push_back({8'h52, 8'h03, 1'b0});
    expq.push_back({8'h59, 8'h02, 1'b0});
    expq.push_back({8'h60, 8'h01, 1'b0});
    set_ready(1);
    cycles(20);
    check("R10 all three delivered", seen, base + 3);

    // R9: level line 7
    set_ready(0);
    reg_wr(8'h1E, 32'h00008070);
    reg_wr(8'h1F, 32'h09000000);
    @(negedge clk) irq_in[7] = 1;
    cycles(10);
    base = seen;
    expq.push_back({8'h70, 8'h09, 1'b0});
    expq.push_back({8'h70, 8'h09, 1'b0});
    set_ready(1);
    for (int k = 0; k < 50; k++) begin
      @(posedge clk); #2;
      if (seen == base + 2) break;
    end
    msg_ready = 0;
    check("R9 level repeats", seen, base + 2);
    irq_in[7] = 0;
    cycles(10);
    @(negedge clk);
    check("R9 committed message kept", {31'b0, msg_valid}, 1);
    expq.push_back({8'h70, 8'h09, 1'b0});
    set_ready(1);
    cycles(30);
    check("R9 stops after release", seen, base + 3);
    check("R10 scoreboard drained", expq.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule